// File: doc/BRIEF.md
# Missing-Pulse Power-Down Detector

This block sits beside the synchronous rectifier drivers and watches the two complementary timing inputs that arrive from the primary-side controller. When those inputs stop switching, both stay high. The block counts the clock cycles for which both are high. Once that run reaches a programmed length, it sets a power-down latch.

While the latch is set, the block does three things. It puts the main drivers into high impedance. It enables a soft pull-down sink on each output. It requests that the reference capacitor be discharged. The detector is live only once the reference has climbed to its arming level, about 90% of nominal. The latch releases only when two things hold together: the reference has fallen to 20% of nominal or below, and the two timing inputs are exactly complementary. On release, a one-cycle restart pulse starts a new soft-start cycle.

Top module: `pulse_loss_guard`

## Requirements
- R1: While `ref_armed` is low, the latch never sets, however long both timing inputs stay high.
- R2: Any sampled cycle in which either timing input is low clears the idle run. A later run must last the full timeout again before the latch sets.
- R3: With the detector armed, both inputs high and `idle_limit` = T (T ≥ 1), the latch is clear after T−1 clock edges and set after the T-th clock edge.
- R4: While the latch is set, `drv_hiz`, `ref_dump` and both bits of `sink_en` are 1. While it is clear, all of them are 0.
- R5: Once set, the latch clears only on an edge where `ref_low` is 1 and exactly one of `tim_a`/`tim_b` is 1. `ref_low` with both inputs equal, or complementary inputs without `ref_low`, leave it set.
- R6: `restart` is 1 for exactly one cycle, in the cycle in which the latch has just cleared, and 0 otherwise.
- R7: An `idle_limit` of 0 acts as 1: one armed edge with both inputs high sets the latch.
- R8: The idle counter stays at zero while the detector is disarmed. After arming, a full T-edge run is needed, even if both inputs were already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_a | input | 1 | Timing input for rectifier A |
| tim_b | input | 1 | Timing input for rectifier B |
| ref_armed | input | 1 | Reference has reached its arming level (about 90% of nominal) |
| ref_low | input | 1 | Reference is at or below 20% of nominal |
| idle_limit | input | TMO_W | Number of both-high cycles that trips the latch |
| drv_hiz | output | 1 | Main drivers to high impedance |
| sink_en | output | NCH | Soft pull-down sink enable per output (bit 0 = A, bit 1 = B) |
| ref_dump | output | 1 | Reference discharge request |
| restart | output | 1 | One-cycle soft-start restart pulse |

## Verification
Two of the block's functions can meet in a single cycle: the idle counter reaching its limit, and the arming flag or a timing input dropping. The bench provokes this by holding both inputs high for T−1 edges and then, on the T-th edge, lowering `ref_armed` or one input. The latch must stay clear, and a later run must again need all T edges. A second overlap, the latch releasing in the same edge the restart pulse is raised, is judged by checking that `drv_hiz` falls and `restart` rises on the same sample, and that `restart` is gone on the next.

// File: rtl/plg_pkg.sv
package plg_pkg;
   localparam int PLG_NCH = 2;

   // Release qualifier: inputs strictly complementary.
   function automatic logic plg_split(input logic a, input logic b);
      return a ^ b;
   endfunction
endpackage

// File: rtl/plg_idle_timer.sv
module plg_idle_timer #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tim_a,
   input  logic             tim_b,
   input  logic             armed,
   input  logic             latched,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   localparam int CW = TMO_W + 1;

   initial assert (TMO_W >= 2 && TMO_W <= 32)
      else $error("plg_idle_timer: TMO_W out of range");

   logic [TMO_W-1:0] cnt;
   logic [CW-1:0]    cnt_inc;
   logic             run;

   assign run     = armed & tim_a & tim_b & ~latched;
   assign cnt_inc = {1'b0, cnt} + CW'(1);
   assign expire  = run & (cnt_inc >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || expire)   cnt <= '0;
      else                       cnt <= cnt_inc[TMO_W-1:0];
   end

   assert_run_breaks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(tim_a && tim_b) |=> cnt == '0);
   assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> cnt == '0);
   assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !expire) |=> cnt != '0);
endmodule

// File: rtl/plg_pd_latch.sv
module plg_pd_latch
   import plg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ref_low,
   input  logic tim_a,
   input  logic tim_b,
   output logic latched,
   output logic restart
);
   logic release_now;

   assign release_now = latched & ref_low & plg_split(tim_a, tim_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= 1'b0;
         restart <= 1'b0;
      end else begin
         restart <= release_now;
         if (release_now)  latched <= 1'b0;
         else if (expire)  latched <= 1'b1;
      end
   end

   assert_set_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latched) |-> $past(expire));
   assert_release_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latched) |-> $past(ref_low && (tim_a != tim_b)));
   assert_restart_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !restart);
   assert_restart_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (!latched && $past(latched)));
endmodule

// File: rtl/pulse_loss_guard.sv
module pulse_loss_guard
   import plg_pkg::*;
#(
   parameter int TMO_W = 16,
   parameter int NCH   = PLG_NCH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tim_a,
   input  logic             tim_b,
   input  logic             ref_armed,
   input  logic             ref_low,
   input  logic [TMO_W-1:0] idle_limit,
   output logic             drv_hiz,
   output logic [NCH-1:0]   sink_en,
   output logic             ref_dump,
   output logic             restart
);
   initial assert (NCH == PLG_NCH)
      else $error("pulse_loss_guard: NCH must match the two timing inputs");

   logic expire;
   logic latched;

   plg_idle_timer #(.TMO_W(TMO_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tim_a   (tim_a),
      .tim_b   (tim_b),
      .armed   (ref_armed),
      .latched (latched),
      .limit   (idle_limit),
      .expire  (expire)
   );

   plg_pd_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .expire  (expire),
      .ref_low (ref_low),
      .tim_a   (tim_a),
      .tim_b   (tim_b),
      .latched (latched),
      .restart (restart)
   );

   assign drv_hiz  = latched;
   assign ref_dump = latched;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_sink
      assign sink_en[ch] = latched;
   end

   assert_disarmed_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_armed && !drv_hiz) |=> !drv_hiz);
   assert_latched_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_hiz && !(ref_low && (tim_a ^ tim_b))) |=> drv_hiz);
endmodule

// File: tb/pulse_loss_guard_bench.sv
module pulse_loss_guard_bench;
   localparam int TMO_W = 16;
   localparam time CLK_P = 4ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tim_a = 1'b0, tim_b = 1'b0, ref_armed = 1'b0, ref_low = 1'b0;
   logic [TMO_W-1:0] idle_limit = '0;
   logic drv_hiz, ref_dump, restart;
   logic [1:0] sink_en;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   pulse_loss_guard #(.TMO_W(TMO_W)) u_pulse_loss_guard (
      .clk(clk), .rst_n(rst_n), .tim_a(tim_a), .tim_b(tim_b),
      .ref_armed(ref_armed), .ref_low(ref_low), .idle_limit(idle_limit),
      .drv_hiz(drv_hiz), .sink_en(sink_en), .ref_dump(ref_dump), .restart(restart)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // Drive at a falling edge, then wait across one rising edge.
   task automatic step(input logic a, input logic b, input logic arm, input logic low);
      tim_a = a; tim_b = b; ref_armed = arm; ref_low = low;
      @(negedge clk);
   endtask

   task automatic check_state(input string req, input int exp_latched);
      chk(req, drv_hiz, exp_latched);
      chk({req, "_dump"}, ref_dump, exp_latched);
      chk({req, "_sink"}, sink_en, exp_latched ? 3 : 0);
   endtask

   // Clear a set latch via the legal release path; checks R5 and R6.
   task automatic release_latch();
      step(1, 1, 0, 1);
      chk("R5 equal inputs hold", drv_hiz, 1);
      step(0, 1, 0, 0);
      chk("R5 no ref_low hold", drv_hiz, 1);
      step(1, 0, 0, 1);
      chk("R5 release", drv_hiz, 0);
      chk("R6 restart high", restart, 1);
      step(1, 0, 0, 0);
      chk("R6 restart single", restart, 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      check_state("reset R4", 0);
      chk("reset R6", restart, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int t = 1; t <= 6; t++) begin
         idle_limit = TMO_W'(t);
         step(1, 0, 1, 0);
         // R3: T-1 edges clear, T-th edge sets.
         for (int k = 1; k < t; k++) step(1, 1, 1, 0);
         check_state("R3 before limit", 0);
         step(1, 1, 1, 0);
         check_state("R3 R4 at limit", 1);
         release_latch();

         // R2: one low cycle breaks the run.
         if (t > 1) begin
            for (int k = 1; k < t; k++) step(1, 1, 1, 0);
            step(0, 1, 1, 0);
            for (int k = 1; k < t; k++) step(1, 1, 1, 0);
            chk("R2 broken run", drv_hiz, 0);
            step(1, 1, 1, 0);
            chk("R2 fresh run trips", drv_hiz, 1);
            release_latch();

            // R2 corner: input falls on the would-be expiry edge.
            for (int k = 1; k < t; k++) step(1, 1, 1, 0);
            step(1, 0, 1, 0);
            chk("R2 drop on expiry edge", drv_hiz, 0);

            // R1 corner: disarm on the would-be expiry edge.
            for (int k = 1; k < t; k++) step(1, 1, 1, 0);
            step(1, 1, 0, 0);
            chk("R1 disarm on expiry edge", drv_hiz, 0);
         end

         // R1, R8: long both-high while disarmed, then a full window.
         for (int k = 0; k < 3 * t + 2; k++) step(1, 1, 0, 0);
         chk("R1 disarmed no set", drv_hiz, 0);
         for (int k = 1; k < t; k++) step(1, 1, 1, 0);
         chk("R8 full window after arm", drv_hiz, 0);
         step(1, 1, 1, 0);
         chk("R8 trips after arm", drv_hiz, 1);
         release_latch();

         // Complementary switching never trips.
         for (int k = 0; k < 4 * t; k++) step(k[0], ~k[0], 1, 0);
         chk("R2 switching no trip", drv_hiz, 0);
      end

      // R7: limit of zero acts as one.
      idle_limit = '0;
      step(0, 1, 1, 0);
      step(1, 1, 1, 0);
      check_state("R7 zero limit", 1);
      release_latch();

      // R5: latch held while switching resumes without ref_low.
      idle_limit = TMO_W'(2);
      step(1, 1, 1, 0);
      step(1, 1, 1, 0);
      for (int k = 0; k < 8; k++) step(k[0], ~k[0], 0, 0);
      chk("R5 switching without ref_low", drv_hiz, 1);
      chk("R6 no restart while held", restart, 0);
      release_latch();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule